// File: doc/BRIEF.md
# Interrupt Source Controller with Event and Level Sources

The controller owns a set of interrupt inputs and decides when each one is offered to the interrupt presenter. Each source has a fixed kind, set by a parameter mask: event sources treat a one-cycle high pulse as one occurrence, and level sources follow a held input. Software sets a target server and a priority for each source. Priority 0xFF masks the source. An event that arrives on a masked event source is held and is delivered once the source is unmasked.

The presenter sends back three kinds of notice. A reject says that a delivery was refused. A resend asks every source to offer itself again. An end-of-interrupt closes the service of a level source. Event and level sources retry differently. A rejected event source comes back only through a resend. A level source comes back whenever it is still asserted and has no delivery outstanding. Deliveries leave one at a time on a valid/ready output. They are numbered globally: local index plus an offset of 16.

Top module: `xsrc_ctrl`

## Requirements
- R1: Source index i has global number 16+i. Only numbers from 16 to 16+NSRC-1 are valid, and every delivery carries the global number.
- R2: After reset every source has server 0 and priority 0xFF (masked), all flags are clear, and no delivery is offered.
- R3: An event pulse on an unmasked event source produces one delivery carrying its server, global number and priority. A pulse on a masked event source produces no delivery and sets its masked-pending flag.
- R4: A level source delivers when it is unmasked, its input has just risen and it has no outstanding delivery, and the delivery marks it sent. A held level produces no further delivery.
- R5: A reject marks the source rejected and clears its sent flag. A reject never triggers a delivery by itself.
- R6: A valid configuration write stores server and priority and then re-evaluates the source. An event source that is masked-pending and now unmasked clears the flag and delivers. A level source that is asserted, unmasked and not sent delivers.
- R7: A configuration write answers one cycle later. The status is 8'hFD (-3) when the number is invalid, the server is not below NSERVER, or the 9-bit priority field exceeds 0xFF (bit 8 set). Otherwise the status is 0. A refused write changes nothing.
- R8: A configuration read answers one cycle later. A valid number gives status 0 with the stored server and priority. An invalid number gives status 8'hFD.
- R9: A resend visits the sources one per cycle in ascending index. A level source applies its R4 rule, without needing a rising input. A rejected event source clears its rejected flag and delivers if it is unmasked.
- R10: An end-of-interrupt clears the sent flag of a level source. It has no effect on an event source.
- R11: At most one delivery is offered at a time, and it holds its fields stable until it is accepted. The resend walk pauses while the offered delivery is not accepted, so that the ascending order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NSRC | Event pulses or levels, one per source |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_num | input | NUM_W | Global source number for the read or write |
| cfg_server | input | CSRV_W | Server number to write |
| cfg_prio | input | 9 | Priority to write; values above 0xFF are refused |
| rsp_valid | output | 1 | Configuration response valid |
| rsp_status | output | 8 | 0 on success, 8'hFD on refusal |
| rsp_server | output | SRV_W | Server returned by a read |
| rsp_prio | output | 8 | Priority returned by a read |
| rej_en | input | 1 | Reject notice strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_en | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Starts a resend walk when none is running |
| dlv_valid | output | 1 | Delivery offered |
| dlv_ready | input | 1 | Presenter accepts the delivery |
| dlv_server | output | SRV_W | Target server of the delivery |
| dlv_num | output | NUM_W | Global source number of the delivery |
| dlv_prio | output | 8 | Priority of the delivery |

## Verification
The bench sends event pulses on masked and on unmasked sources. This separates immediate delivery from latched delivery on unmask. Level inputs are raised and then held across rejects, resends and end-of-interrupt notices. This shows whether a reject is wrongly treated as a retry, and whether a level source is rightly re-armed only by end-of-interrupt or reject. A resend with two rejected event sources and the ready input held low shows both the ascending walk and the stall. Configuration writes with a bad number, a bad server and an oversized priority are each followed by a read-back, which proves that the refusal left the source unchanged.

// File: rtl/xsrc_pkg.sv
// Shared types and constants for the interrupt source controller.
// Assumes 8-bit priorities where the all-ones value means masked.
package xsrc_pkg;
    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic mpend;
        logic pend;
    } xsrc_flags_t;

    localparam logic [7:0] PRIO_OFF  = 8'hFF;
    localparam logic [7:0] STAT_OK   = 8'h00;
    localparam logic [7:0] STAT_BAD  = 8'hFD;
endpackage

// File: rtl/xsrc_decode.sv
// Turns a global source number into a one-hot hit vector over local indices.
// Assumes OFFSET+NSRC fits in NUM_W bits.
module xsrc_decode #(
    parameter int NSRC   = 8,
    parameter int OFFSET = 16,
    parameter int NUM_W  = 8
) (
    input  logic             en,
    input  logic [NUM_W-1:0] num,
    output logic [NSRC-1:0]  hit
);
    // One comparator per source index.
    for (genvar i = 0; i < NSRC; i++) begin : g_hit
        assign hit[i] = en && (num == NUM_W'(OFFSET + i));
    end
endmodule

// File: rtl/xsrc_pick.sv
// Fixed-priority selector: the lowest requesting index wins.
module xsrc_pick #(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  logic [NSRC-1:0]  req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest index is assigned last.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xsrc_slot.sv
// State of one interrupt source: target server, priority and flags.
// IS_LEVEL picks level behaviour, otherwise event behaviour. All strobes are
// already decoded for this slot; at most one delivery is granted per cycle.
module xsrc_slot
    import xsrc_pkg::*;
#(
    parameter int SRV_W    = 2,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             grant,
    input  logic             rej_hit,
    input  logic             eoi_hit,
    input  logic             wr_hit,
    input  logic [SRV_W-1:0] wr_server,
    input  logic [7:0]       wr_prio,
    input  logic             scan_hit,
    output logic             req,
    output logic [SRV_W-1:0] server,
    output logic [7:0]       prio
);
    xsrc_flags_t      flg, flg_n;
    logic [SRV_W-1:0] srv_n;
    logic [7:0]       prio_n;
    logic             rise;

    // Next-state: grant clears first, then notices, config, input and scan.
    always_comb begin
        flg_n  = flg;
        srv_n  = server;
        prio_n = prio;
        rise   = 1'b0;
        if (grant) flg_n.pend = 1'b0;
        if (rej_hit) begin
            flg_n.rejected = 1'b1;
            flg_n.sent     = 1'b0;
        end
        if (eoi_hit && IS_LEVEL) flg_n.sent = 1'b0;
        if (wr_hit) begin
            srv_n  = wr_server;
            prio_n = wr_prio;
        end
        if (IS_LEVEL) begin
            rise           = sig_in && !flg.asserted;
            flg_n.asserted = sig_in;
            if ((wr_hit || rise || scan_hit) && prio_n != PRIO_OFF
                && flg_n.asserted && !flg_n.sent) begin
                flg_n.pend = 1'b1;
                flg_n.sent = 1'b1;
            end
        end else begin
            if (wr_hit && flg_n.mpend && prio_n != PRIO_OFF) begin
                flg_n.mpend = 1'b0;
                flg_n.pend  = 1'b1;
            end
            if (sig_in) begin
                if (prio_n == PRIO_OFF) flg_n.mpend = 1'b1;
                else                    flg_n.pend  = 1'b1;
            end
            if (scan_hit && flg_n.rejected) begin
                flg_n.rejected = 1'b0;
                if (prio_n != PRIO_OFF) flg_n.pend = 1'b1;
            end
        end
    end

    // State register with masked reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg    <= '0;
            server <= '0;
            prio   <= PRIO_OFF;
        end else begin
            flg    <= flg_n;
            server <= srv_n;
            prio   <= prio_n;
        end
    end

    assign req = flg.pend && (prio != PRIO_OFF);
endmodule

// File: rtl/xsrc_ctrl.sv
// Interrupt source controller top. It decodes configuration and presenter
// notices, runs the resend walk and issues one delivery at a time on a
// valid/ready port. Assumes a write and a read never arrive in one cycle
// (the write wins).
module xsrc_ctrl
    import xsrc_pkg::*;
#(
    parameter int              NSRC       = 8,
    parameter int              NSERVER    = 4,
    parameter int              OFFSET     = 16,
    parameter int              NUM_W      = 8,
    parameter int              CSRV_W     = 8,
    parameter logic [NSRC-1:0] LEVEL_MASK = 8'hF0,
    localparam int             SRV_W      = (NSERVER > 1) ? $clog2(NSERVER) : 1,
    localparam int             IDX_W      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              cfg_wr_en,
    input  logic              cfg_rd_en,
    input  logic [NUM_W-1:0]  cfg_num,
    input  logic [CSRV_W-1:0] cfg_server,
    input  logic [8:0]        cfg_prio,
    output logic              rsp_valid,
    output logic [7:0]        rsp_status,
    output logic [SRV_W-1:0]  rsp_server,
    output logic [7:0]        rsp_prio,
    input  logic              rej_en,
    input  logic [NUM_W-1:0]  rej_num,
    input  logic              eoi_en,
    input  logic [NUM_W-1:0]  eoi_num,
    input  logic              resend_req,
    output logic              dlv_valid,
    input  logic              dlv_ready,
    output logic [SRV_W-1:0]  dlv_server,
    output logic [NUM_W-1:0]  dlv_num,
    output logic [7:0]        dlv_prio
);
    logic [NSRC-1:0]  cfg_hit, rej_hit, eoi_hit, wr_hit, scan_hit, grant, req;
    logic [SRV_W-1:0] srv_a [NSRC];
    logic [7:0]       prio_a [NSRC];
    logic             num_ok, wr_ok, stall, can_load, any_req;
    logic             scan_on;
    logic [IDX_W-1:0] scan_idx, pick;
    logic [SRV_W-1:0] rd_srv;
    logic [7:0]       rd_prio;

    xsrc_decode #(.NSRC(NSRC), .OFFSET(OFFSET), .NUM_W(NUM_W)) u_dec_cfg (
        .en(1'b1), .num(cfg_num), .hit(cfg_hit));
    xsrc_decode #(.NSRC(NSRC), .OFFSET(OFFSET), .NUM_W(NUM_W)) u_dec_rej (
        .en(rej_en), .num(rej_num), .hit(rej_hit));
    xsrc_decode #(.NSRC(NSRC), .OFFSET(OFFSET), .NUM_W(NUM_W)) u_dec_eoi (
        .en(eoi_en), .num(eoi_num), .hit(eoi_hit));

    // Write validation: number, server range and 8-bit priority.
    assign num_ok = |cfg_hit;
    assign wr_ok  = num_ok && (cfg_server < CSRV_W'(NSERVER)) && !cfg_prio[8];
    assign wr_hit = (cfg_wr_en && wr_ok) ? cfg_hit : '0;

    // Delivery port handshake state.
    assign stall    = dlv_valid && !dlv_ready;
    assign can_load = !stall;

    // Per-source state slots; the kind mask picks the variant.
    for (genvar i = 0; i < NSRC; i++) begin : g_slot
        assign scan_hit[i] = scan_on && !stall && (scan_idx == IDX_W'(i));
        assign grant[i]    = can_load && any_req && (pick == IDX_W'(i));
        xsrc_slot #(.SRV_W(SRV_W), .IS_LEVEL(LEVEL_MASK[i])) u_slot (
            .clk(clk), .rst_n(rst_n), .sig_in(src_in[i]), .grant(grant[i]),
            .rej_hit(rej_hit[i]), .eoi_hit(eoi_hit[i]), .wr_hit(wr_hit[i]),
            .wr_server(cfg_server[SRV_W-1:0]), .wr_prio(cfg_prio[7:0]),
            .scan_hit(scan_hit[i]), .req(req[i]),
            .server(srv_a[i]), .prio(prio_a[i]));
    end

    xsrc_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
        .req(req), .any(any_req), .idx(pick));

    // Read-data mux over the decoded slot.
    always_comb begin
        rd_srv  = '0;
        rd_prio = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cfg_hit[i]) begin
                rd_srv  = srv_a[i];
                rd_prio = prio_a[i];
            end
        end
    end

    // Configuration response register, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= STAT_OK;
            rsp_server <= '0;
            rsp_prio   <= '0;
        end else begin
            rsp_valid  <= cfg_wr_en || cfg_rd_en;
            rsp_server <= '0;
            rsp_prio   <= '0;
            if (cfg_wr_en) begin
                rsp_status <= wr_ok ? STAT_OK : STAT_BAD;
            end else if (cfg_rd_en) begin
                rsp_status <= num_ok ? STAT_OK : STAT_BAD;
                if (num_ok) begin
                    rsp_server <= rd_srv;
                    rsp_prio   <= rd_prio;
                end
            end
        end
    end

    // Resend walk: one index per unstalled cycle, ascending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_on  <= 1'b0;
            scan_idx <= '0;
        end else if (scan_on) begin
            if (!stall) begin
                if (scan_idx == IDX_W'(NSRC - 1)) scan_on <= 1'b0;
                else                               scan_idx <= scan_idx + 1'b1;
            end
        end else if (resend_req) begin
            scan_on  <= 1'b1;
            scan_idx <= '0;
        end
    end

    // Delivery register: loads the winner whenever the port is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid  <= 1'b0;
            dlv_server <= '0;
            dlv_num    <= '0;
            dlv_prio   <= '0;
        end else if (can_load) begin
            dlv_valid <= any_req;
            if (any_req) begin
                dlv_server <= srv_a[pick];
                dlv_prio   <= prio_a[pick];
                dlv_num    <= NUM_W'(OFFSET) + NUM_W'(pick);
            end
        end
    end
endmodule

// File: rtl/xsrc_ctrl_chk.sv
// Property checker for xsrc_ctrl, attached by bind. Observes ports only.
module xsrc_ctrl_chk #(
    parameter int NSRC   = 8,
    parameter int OFFSET = 16,
    parameter int NUM_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic             cfg_rd_en,
    input logic [NUM_W-1:0] cfg_num,
    input logic             rsp_valid,
    input logic [7:0]       rsp_status,
    input logic             dlv_valid,
    input logic             dlv_ready,
    input logic [NUM_W-1:0] dlv_num,
    input logic [7:0]       dlv_prio
);
    logic bad_num;
    assign bad_num = (int'(cfg_num) < OFFSET) || (int'(cfg_num) >= OFFSET + NSRC);

    AST_DLV_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (int'(dlv_num) >= OFFSET && int'(dlv_num) < OFFSET + NSRC)); // R1
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!dlv_valid && !rsp_valid)); // R2
    AST_DLV_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> dlv_prio != 8'hFF); // R3
    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en || cfg_rd_en) |=> rsp_valid); // R7
    AST_RSP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status == 8'h00 || rsp_status == 8'hFD)); // R7
    AST_BAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_en && !cfg_wr_en && bad_num) |=> rsp_status == 8'hFD); // R8
    AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_num) && $stable(dlv_prio))); // R11
endmodule

bind xsrc_ctrl xsrc_ctrl_chk #(.NSRC(NSRC), .OFFSET(OFFSET), .NUM_W(NUM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_num(cfg_num), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_num(dlv_num),
    .dlv_prio(dlv_prio));

// File: tb/xsrc_ctrl_bench.sv
// Scoreboard bench: tasks queue expected deliveries, a monitor pops them.
// Sources 0..3 are event sources and 4..7 are level sources (default mask).
module xsrc_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_in = '0;
    logic       cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [7:0] cfg_num = '0, cfg_server = '0;
    logic [8:0] cfg_prio = '0;
    logic       rsp_valid;
    logic [7:0] rsp_status, rsp_prio;
    logic [1:0] rsp_server;
    logic       rej_en = 1'b0, eoi_en = 1'b0, resend_req = 1'b0;
    logic [7:0] rej_num = '0, eoi_num = '0;
    logic       dlv_valid, dlv_ready = 1'b1;
    logic [1:0] dlv_server;
    logic [7:0] dlv_num, dlv_prio;

    int    checks = 0, errors = 0;
    string cur_tag = "R2";
    logic [17:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    xsrc_ctrl u_xsrc_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_wr_en(cfg_wr_en),
        .cfg_rd_en(cfg_rd_en), .cfg_num(cfg_num), .cfg_server(cfg_server),
        .cfg_prio(cfg_prio), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_server(rsp_server), .rsp_prio(rsp_prio), .rej_en(rej_en),
        .rej_num(rej_num), .eoi_en(eoi_en), .eoi_num(eoi_num),
        .resend_req(resend_req), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
        .dlv_server(dlv_server), .dlv_num(dlv_num), .dlv_prio(dlv_prio));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each accepted delivery with the queue head.
    always @(negedge clk) begin
        if (rst_n && dlv_valid && dlv_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected delivery"},
                      int'({dlv_server, dlv_num, dlv_prio}), 0);
            end else begin
                automatic logic [17:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check({dlv_server, dlv_num, dlv_prio} == e, t,
                      int'({dlv_server, dlv_num, dlv_prio}), int'(e));
            end
        end
    end

    task automatic expect_dlv(input logic [1:0] s, input logic [7:0] n,
                              input logic [7:0] p, input string tag);
        exp_q.push_back({s, n, p});
        tag_q.push_back(tag);
    endtask

    task automatic settle(input int n, input string tag);
        repeat (n) @(posedge clk);
        #2;
        check(exp_q.size() == 0, {tag, " missing delivery"}, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic cfg_write(input logic [7:0] n, input logic [7:0] s,
                             input logic [8:0] p, input logic [7:0] st, input string tag);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1; cfg_num = n; cfg_server = s; cfg_prio = p;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
        check(rsp_valid && rsp_status == st, {tag, " write status"},
              int'({rsp_valid, rsp_status}), int'({1'b1, st}));
    endtask

    task automatic cfg_read(input logic [7:0] n, input logic [7:0] st,
                            input logic [1:0] s, input logic [7:0] p, input string tag);
        @(posedge clk); #1;
        cfg_rd_en = 1'b1; cfg_num = n;
        @(posedge clk); #1;
        cfg_rd_en = 1'b0;
        check(rsp_valid && rsp_status == st && (st != 8'h00 || (rsp_server == s && rsp_prio == p)),
              {tag, " read"}, int'({rsp_valid, rsp_status, rsp_server, rsp_prio}),
              int'({1'b1, st, s, p}));
    endtask

    task automatic pulse(input int i);
        @(posedge clk); #1; src_in[i] = 1'b1;
        @(posedge clk); #1; src_in[i] = 1'b0;
    endtask

    task automatic level(input int i, input logic v);
        @(posedge clk); #1; src_in[i] = v;
    endtask

    task automatic reject(input logic [7:0] n);
        @(posedge clk); #1; rej_en = 1'b1; rej_num = n;
        @(posedge clk); #1; rej_en = 1'b0;
    endtask

    task automatic end_irq(input logic [7:0] n);
        @(posedge clk); #1; eoi_en = 1'b1; eoi_num = n;
        @(posedge clk); #1; eoi_en = 1'b0;
    endtask

    task automatic resend();
        @(posedge clk); #1; resend_req = 1'b1;
        @(posedge clk); #1; resend_req = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1 check(!dlv_valid && !rsp_valid, "R2 idle after reset", dlv_valid, 0);
        cfg_read(8'd16, 8'h00, 2'd0, 8'hFF, "R2 source 16 masked");
        cfg_read(8'd23, 8'h00, 2'd0, 8'hFF, "R2 source 23 masked");

        cur_tag = "R1";
        cfg_read(8'd15, 8'hFD, 2'd0, 8'h00, "R1 R8 below range");
        cfg_read(8'd24, 8'hFD, 2'd0, 8'h00, "R1 R8 above range");

        cur_tag = "R7";
        cfg_write(8'd24, 8'd1, 9'd5, 8'hFD, "R7 bad number");
        cfg_write(8'd17, 8'd4, 9'd5, 8'hFD, "R7 bad server");
        cfg_write(8'd17, 8'd1, 9'h100, 8'hFD, "R7 bad priority");
        cfg_read(8'd17, 8'h00, 2'd0, 8'hFF, "R7 refused write left state");

        cur_tag = "R3";
        pulse(0);
        settle(4, "R3 masked event holds");
        expect_dlv(2'd1, 8'd16, 8'd5, "R6 unmask releases masked-pending");
        cfg_write(8'd16, 8'd1, 9'd5, 8'h00, "R6 write");
        settle(4, "R6");
        cfg_read(8'd16, 8'h00, 2'd1, 8'd5, "R8 read back");
        expect_dlv(2'd1, 8'd16, 8'd5, "R3 unmasked event");
        pulse(0);
        settle(4, "R3");

        cur_tag = "R6";
        cfg_write(8'd20, 8'd2, 9'd3, 8'h00, "R6 level write unasserted");
        settle(4, "R6 no delivery unasserted");
        cur_tag = "R4";
        expect_dlv(2'd2, 8'd20, 8'd3, "R4 level rise");
        level(4, 1'b1);
        settle(6, "R4 held level single delivery");

        cur_tag = "R5";
        reject(8'd20);
        settle(4, "R5 reject no redelivery");
        expect_dlv(2'd2, 8'd20, 8'd3, "R9 level resend after reject");
        resend();
        settle(12, "R9 level resend");

        cur_tag = "R10";
        resend();
        settle(12, "R10 sent blocks resend");
        end_irq(8'd20);
        settle(4, "R10 eoi alone no delivery");
        expect_dlv(2'd2, 8'd20, 8'd3, "R10 resend after eoi");
        resend();
        settle(12, "R10 level");
        level(4, 1'b0);

        cur_tag = "R5";
        reject(8'd16);
        settle(4, "R5 event reject no redelivery");
        cur_tag = "R10";
        end_irq(8'd16);
        settle(4, "R10 eoi on event no effect");
        expect_dlv(2'd1, 8'd16, 8'd5, "R9 event resend after reject");
        resend();
        settle(12, "R9 event");
        cur_tag = "R9";
        resend();
        settle(12, "R9 rejected flag cleared");

        cur_tag = "R11";
        cfg_write(8'd17, 8'd3, 9'd7, 8'h00, "R11 setup 17");
        cfg_write(8'd19, 8'd0, 9'd2, 8'h00, "R11 setup 19");
        reject(8'd19);
        reject(8'd17);
        @(posedge clk); #1 dlv_ready = 1'b0;
        expect_dlv(2'd3, 8'd17, 8'd7, "R9 R11 ascending first");
        expect_dlv(2'd0, 8'd19, 8'd2, "R9 R11 ascending second");
        resend();
        repeat (6) @(posedge clk);
        #2 check(dlv_valid && dlv_num == 8'd17, "R11 held while stalled", dlv_num, 17);
        repeat (3) @(posedge clk);
        #2 check(dlv_valid && dlv_num == 8'd17, "R11 still stable", dlv_num, 17);
        @(posedge clk); #1 dlv_ready = 1'b1;
        settle(12, "R11 stalled resend");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule